// File: doc/BRIEF.md
# Latched One-of-Sixteen Decoder with Demultiplexer Enable

This block keeps a 4-bit destination address in a capture stage and turns it into one active line out of sixteen. While the capture control is high the stage is transparent, so the outputs follow the address pins in the same cycle. The stage also samples the address on each rising clock edge while the control is high. Once the control goes low, the last sampled address is held and the address pins are ignored.

A low-true enable gates the decode directly and is never held. When the enable is high, every output sits at its idle level. If a serial data bit is driven onto the enable while the address picks a destination, the block works as a one-to-sixteen demultiplexer. The same enable serves as a chip select when several blocks share an address bus.

A build-time parameter sets the output sense: either the chosen line is high and the rest are low, or the chosen line is low and the rest are high.

Top module: `latched_line_decoder`

## Requirements
- R1: With the enable low, exactly one output is active: output i, where i is the unsigned value of the effective 4-bit address (bit 0 is the least significant).
- R2: While latchEn is high the capture stage is transparent: a change on addrIn moves the active output within the same cycle, with no clock edge needed.
- R3: While latchEn is low the outputs decode the address sampled at the last rising clock edge on which latchEn was high, and changes on addrIn have no effect.
- R4: While enableN is high, all sixteen outputs sit at the idle level, whatever the address and latchEn.
- R5: The enable is not held: a change on enableN reaches the outputs in the same cycle, also while latchEn is low.
- R6: As a demultiplexer, the addressed output carries the data bit driven on enableN (active when the bit is 0, idle when it is 1), and all other outputs stay idle.
- R7: With ACTIVE_HIGH=1 the active level is 1 and the idle level is 0. With ACTIVE_HIGH=0 the active level is 0 and the idle level is 1.
- R8: An active-low rstN clears the held address to 0, so after reset, with latchEn low and enableN low, output 0 is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the address while latchEn is high |
| rstN | input | 1 | Asynchronous active-low reset; clears the held address |
| addrIn | input | 4 | Destination address |
| latchEn | input | 1 | High: transparent and sampling; low: hold |
| enableN | input | 1 | Low-true enable, also the demultiplexer data input |
| yOut | output | 16 | Decoded lines, sense set by ACTIVE_HIGH |

## Verification
On every cycle the assertions check four things: that at most one line is active, and exactly one while enabled; that a high enable forces every line idle; that the active line matches the address pins while transparent; and that the outputs stay stable while both the hold and the enable are steady. Only the bench scenarios can show that the held value is the last address sampled before the hold began, that the reset value is address zero, and that the two output senses are exact complements over all sixteen addresses. These scenarios drive two instances, one for each sense, with directed sweeps and a seeded random mix of address, hold and enable changes.

// File: rtl/decoder_pkg.sv
package decoder_pkg;
  typedef struct packed {
    logic capture;  // sample and pass through the address
    logic select;   // allow a line to go active
  } decStrobes_t;
endpackage

// File: rtl/decoder_ctrl.sv
module decoder_ctrl
  import decoder_pkg::*;
(
  input  logic        latchEn,
  input  logic        enableN,
  output decStrobes_t strobes
);
  // Both strobes act in the same cycle; the enable is deliberately never stored.
  always_comb begin
    strobes.capture = latchEn;
    strobes.select  = ~enableN;
  end
endmodule

// File: rtl/decoder_datapath.sv
module decoder_datapath
  import decoder_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter bit ACTIVE_HIGH = 1'b1,
  localparam int LINES      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  decStrobes_t       strobes,
  output logic [LINES-1:0]  yOut
);
  logic [ADDR_W-1:0] heldAddr;
  logic [ADDR_W-1:0] effAddr;
  logic [LINES-1:0]  hot;
  logic [LINES-1:0]  activeView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                heldAddr <= '0;
    else if (strobes.capture) heldAddr <= addrIn;
  end

  assign effAddr = strobes.capture ? addrIn : heldAddr;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hot[i] = strobes.select && (effAddr == ADDR_W'(i));
    if (ACTIVE_HIGH) begin : g_hi
      assign yOut[i] = hot[i];
    end else begin : g_lo
      assign yOut[i] = ~hot[i];
    end
  end

  // Outputs seen through the active level, independent of the decode path
  assign activeView = ACTIVE_HIGH ? yOut : ~yOut;

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.select |-> $countones(activeView) == 1); // R1
  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.select) |-> activeView[addrIn]); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && $past(!strobes.capture) && strobes.select && $past(strobes.select))
      |-> $stable(yOut)); // R3
  AST_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.select |-> activeView == '0); // R4
  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(activeView)); // R6
endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder
  import decoder_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter bit ACTIVE_HIGH = 1'b1,
  localparam int LINES      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              latchEn,
  input  logic              enableN,
  output logic [LINES-1:0]  yOut
);
  decStrobes_t strobes;

  decoder_ctrl u_ctrl (
    .latchEn (latchEn),
    .enableN (enableN),
    .strobes (strobes)
  );

  decoder_datapath #(.ADDR_W(ADDR_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .strobes (strobes),
    .yOut    (yOut)
  );
endmodule

// File: tb/tb_latched_line_decoder.sv
module tb_latched_line_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] addrIn = '0;
  logic latchEn = 1'b0;
  logic enableN = 1'b0;
  logic [15:0] yHi, yLo;
  logic [3:0] modelHeld = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  latched_line_decoder #(.ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .latchEn(latchEn), .enableN(enableN), .yOut(yHi));
  latched_line_decoder #(.ACTIVE_HIGH(1'b0)) dutLow (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .latchEn(latchEn), .enableN(enableN), .yOut(yLo));

  function automatic logic [15:0] expectLines(input logic [3:0] a, input logic en, input bit hiSense);
    logic [15:0] v;
    v = en ? '0 : (16'h1 << a);
    return hiSense ? v : ~v;
  endfunction

  task automatic check(input string req);
    logic [3:0] eff;
    logic [15:0] eHi, eLo;
    eff = latchEn ? addrIn : modelHeld;
    eHi = expectLines(eff, enableN, 1'b1);
    eLo = expectLines(eff, enableN, 1'b0);
    checks++;
    if (yHi !== eHi || yLo !== eLo) begin
      errors++;
      $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h", req, yHi, yLo, eHi, eLo);
    end
  endtask

  // Drive at falling edge, check mid-phase, then let the rising edge update the model
  task automatic step(input logic [3:0] a, input logic le, input logic en, input string req);
    @(negedge clk);
    addrIn = a; latchEn = le; enableN = en;
    #1 check(req);
    @(posedge clk);
    if (le) modelHeld = a;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1 check("R8 during reset");
    rstN = 1'b1;
    step(4'd9, 1'b0, 1'b0, "R8 reset address zero held");
    // R1 R7: sweep all addresses, transparent, both senses
    for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 1'b0, "R1 R7 sweep");
    // R2: address change within transparent phase
    step(4'd3, 1'b1, 1'b0, "R2 follow");
    @(negedge clk); addrIn = 4'd12; #1 check("R2 same-cycle change");
    @(posedge clk); modelHeld = 4'd12;
    // R3: hold
    step(4'd5, 1'b1, 1'b0, "R3 capture");
    step(4'd10, 1'b0, 1'b0, "R3 hold ignores address");
    step(4'd15, 1'b0, 1'b0, "R3 hold ignores address again");
    // R4: enable high inhibits
    step(4'd7, 1'b1, 1'b1, "R4 inhibit transparent");
    step(4'd2, 1'b0, 1'b1, "R4 inhibit hold");
    // R5: enable acts while held
    step(4'd0, 1'b0, 1'b0, "R5 enable during hold");
    @(negedge clk); enableN = 1'b1; #1 check("R5 same-cycle disable");
    @(posedge clk);
    // R6: demux data bits to address 6
    step(4'd6, 1'b1, 1'b0, "R6 capture destination");
    for (int b = 0; b < 8; b++) step(4'd1, 1'b0, logic'((8'b1011_0010 >> b) & 1), "R6 serial data");
    // Random mix
    for (int k = 0; k < 300; k++)
      step(4'($urandom_range(15)), logic'($urandom_range(1)), logic'($urandom_range(3) == 0), "R1 R3 R4 random");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule